// File: doc/BRIEF.md
# PLL Control Register Bank with Half-Word Write Masks

This block holds the programming state of one clock synthesizer on a simple register bus. It keeps four 32-bit words. Three of them take masked writes: the upper half of the write data is a per-bit enable for the lower half. Software can therefore change one field without first reading the word back. The fourth word carries the 24-bit fractional multiplier and takes plain full-word writes. Its top bit reports the lock flag of the analog loop, and that bit cannot be written.

The stored fields drive the synthesizer directly: feedback divider, reference divider, two output dividers, fractional value, fractional-mode disable, powerdown and loop reset. A separate enable flag is the inverse of powerdown. A read request returns the selected word on the clock edge that follows it. The bus protocol conversion and the analog loop sit outside this block.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the outputs are: feedback divider 50, reference divider 1, first output divider 1, second output divider 1, fractional value 0, fractional-mode disable 1, powerdown 0, loop reset 0 and read data 0.
- R2: In the masked words (byte addresses 0x0, 0x4 and 0xC), lower bit k (k = 0..15) takes write-data bit k only when write-data bit 16+k is 1 in the same write. Every other bit keeps its value.
- R3: Field positions are as follows. Word 0x0 holds the feedback divider in bits [11:0]. Word 0x4 holds the reference divider in [5:0], the first output divider in [10:8] and the second output divider in [14:12]. A write shows on the outputs on the clock edge that takes it.
- R4: Word 0xC holds powerdown in bit 0, fractional-mode disable in bit 3 and loop reset in bit 5. The enable output is always the inverse of powerdown.
- R5: A write to word 0x8 replaces the fractional value with write-data [23:0], whatever the upper 16 bits hold.
- R6: A read of word 0x8 returns the lock input in bit 31, zeros in [30:24] and the fractional value in [23:0]. The lock input is taken at the edge that accepts the read.
- R7: A read of a masked word returns 0 in bits [31:16] and in every bit that belongs to no field.
- R8: Read data is loaded only on the edge that accepts a read request. It holds through idle cycles and through writes.
- R9: The word is chosen by address bits [3:2]. Address bits [1:0] have no effect.
- R10: When the request valid is low, no stored field changes, whatever the other bus inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A bus access is requested this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Byte address; bits [3:2] choose the word |
| req_wdata | input | 32 | Write data, with the mask in the upper half for masked words |
| rd_data | output | 32 | Read data, loaded one edge after a read request |
| lock_in | input | 1 | Lock flag from the analog loop |
| fb_div | output | 12 | Feedback divider |
| ref_div | output | 6 | Reference divider |
| out_div_a | output | 3 | First output divider |
| out_div_b | output | 3 | Second output divider |
| frac_val | output | 24 | Fractional multiplier |
| frac_off | output | 1 | Fractional mode disabled (integer mode) |
| pwr_down | output | 1 | Synthesizer powered down |
| loop_rst | output | 1 | Synthesizer loop held in reset |
| pll_enabled | output | 1 | Inverse of powerdown |

## Verification
Masked writes are tried with three mask patterns: a full mask, a partial mask, and a zero mask with data ones underneath. Together they separate a correct merge from one that ignores the mask, inverts it, or applies it to the wrong half. The fractional word is written with its upper bits set. This tells a plain write apart from a masked one, and it is read with the lock input both high and low. Writes that touch undefined bit positions, reads with nonzero low address bits, and bus inputs driven while valid is low show whether anything leaks into unused bits or wrong words. A behavioural model is compared against every output on every cycle.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

    localparam int HALF_W   = 16;
    localparam int FB_W     = 12;
    localparam int REF_W    = 6;
    localparam int ODIV_W   = 3;
    localparam int FRAC_W   = 24;
    localparam int DATA_W   = 32;

    localparam int ODA_LSB  = 8;
    localparam int ODB_LSB  = 12;
    localparam int PD_BIT   = 0;
    localparam int DSM_BIT  = 3;
    localparam int RST_BIT  = 5;
    localparam int LOCK_BIT = 31;

    localparam int NUM_MASKED = 3;

    localparam logic [1:0] W_FB   = 2'd0;
    localparam logic [1:0] W_DIV  = 2'd1;
    localparam logic [1:0] W_FRAC = 2'd2;
    localparam logic [1:0] W_CTL  = 2'd3;

    typedef struct packed {
        logic [FB_W-1:0]   fb;
        logic [REF_W-1:0]  refd;
        logic [ODIV_W-1:0] oda;
        logic [ODIV_W-1:0] odb;
        logic [FRAC_W-1:0] frac;
        logic              pd;
        logic              dsm_off;
        logic              lrst;
        logic [DATA_W-1:0] rd;
    } ctrl_t;

    function automatic logic [HALF_W-1:0] img_fb(input ctrl_t s);
        logic [HALF_W-1:0] v;
        v = '0;
        v[FB_W-1:0] = s.fb;
        return v;
    endfunction

    function automatic logic [HALF_W-1:0] img_div(input ctrl_t s);
        logic [HALF_W-1:0] v;
        v = '0;
        v[REF_W-1:0] = s.refd;
        v[ODA_LSB +: ODIV_W] = s.oda;
        v[ODB_LSB +: ODIV_W] = s.odb;
        return v;
    endfunction

    function automatic logic [HALF_W-1:0] img_ctl(input ctrl_t s);
        logic [HALF_W-1:0] v;
        v = '0;
        v[PD_BIT]  = s.pd;
        v[DSM_BIT] = s.dsm_off;
        v[RST_BIT] = s.lrst;
        return v;
    endfunction

endpackage

// File: rtl/pll_hw_merge.sv
module pll_hw_merge #(
    parameter int HALF = 16
) (
    input  logic [HALF-1:0]   cur_i,
    input  logic [2*HALF-1:0] wr_i,
    output logic [HALF-1:0]   nxt_o
);
    logic [HALF-1:0] en;
    assign en    = wr_i[2*HALF-1:HALF];
    assign nxt_o = (cur_i & ~en) | (wr_i[HALF-1:0] & en);
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux
    import pll_ctrl_pkg::*;
(
    input  logic [1:0]        word_i,
    input  logic [HALF_W-1:0] fb_img_i,
    input  logic [HALF_W-1:0] div_img_i,
    input  logic [HALF_W-1:0] ctl_img_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              lock_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        case (word_i)
            W_FB:    data_o[HALF_W-1:0] = fb_img_i;
            W_DIV:   data_o[HALF_W-1:0] = div_img_i;
            W_FRAC: begin
                data_o[FRAC_W-1:0] = frac_i;
                data_o[LOCK_BIT]   = lock_i;
            end
            default: data_o[HALF_W-1:0] = ctl_img_i;
        endcase
    end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
    import pll_ctrl_pkg::*;
#(
    parameter logic [FB_W-1:0]   FB_RST  = 12'd50,
    parameter logic [REF_W-1:0]  REF_RST = 6'd1,
    parameter logic [ODIV_W-1:0] ODA_RST = 3'd1,
    parameter logic [ODIV_W-1:0] ODB_RST = 3'd1,
    parameter logic              DSM_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lock_in,
    output logic [FB_W-1:0]   fb_div,
    output logic [REF_W-1:0]  ref_div,
    output logic [ODIV_W-1:0] out_div_a,
    output logic [ODIV_W-1:0] out_div_b,
    output logic [FRAC_W-1:0] frac_val,
    output logic              frac_off,
    output logic              pwr_down,
    output logic              loop_rst,
    output logic              pll_enabled
);
    localparam logic [1:0] MASKED_WORD [NUM_MASKED] = '{W_FB, W_DIV, W_CTL};

    ctrl_t state_q, state_d;

    logic [1:0]        word;
    logic              unused_addr_bits;
    logic [HALF_W-1:0] img_q   [NUM_MASKED];
    logic [HALF_W-1:0] img_new [NUM_MASKED];
    logic [DATA_W-1:0] rd_sel;

    assign word             = req_addr[3:2];
    assign unused_addr_bits = ^req_addr[1:0];

    assign img_q[0] = img_fb(state_q);
    assign img_q[1] = img_div(state_q);
    assign img_q[2] = img_ctl(state_q);

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_merge
        pll_hw_merge #(.HALF(HALF_W)) u_merge (
            .cur_i (img_q[g]),
            .wr_i  (req_wdata),
            .nxt_o (img_new[g])
        );
    end

    pll_rd_mux u_rd_mux (
        .word_i    (word),
        .fb_img_i  (img_q[0]),
        .div_img_i (img_q[1]),
        .ctl_img_i (img_q[2]),
        .frac_i    (state_q.frac),
        .lock_i    (lock_in),
        .data_o    (rd_sel)
    );

    always_comb begin
        state_d = state_q;
        if (req_valid && req_write) begin
            if (word == MASKED_WORD[0]) begin
                state_d.fb = img_new[0][FB_W-1:0];
            end
            if (word == MASKED_WORD[1]) begin
                state_d.refd = img_new[1][REF_W-1:0];
                state_d.oda  = img_new[1][ODA_LSB +: ODIV_W];
                state_d.odb  = img_new[1][ODB_LSB +: ODIV_W];
            end
            if (word == MASKED_WORD[2]) begin
                state_d.pd      = img_new[2][PD_BIT];
                state_d.dsm_off = img_new[2][DSM_BIT];
                state_d.lrst    = img_new[2][RST_BIT];
            end
            if (word == W_FRAC) begin
                state_d.frac = req_wdata[FRAC_W-1:0];
            end
        end
        if (req_valid && !req_write) begin
            state_d.rd = rd_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.fb      <= FB_RST;
            state_q.refd    <= REF_RST;
            state_q.oda     <= ODA_RST;
            state_q.odb     <= ODB_RST;
            state_q.frac    <= '0;
            state_q.pd      <= 1'b0;
            state_q.dsm_off <= DSM_RST;
            state_q.lrst    <= 1'b0;
            state_q.rd      <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fb_div      = state_q.fb;
    assign ref_div     = state_q.refd;
    assign out_div_a   = state_q.oda;
    assign out_div_b   = state_q.odb;
    assign frac_val    = state_q.frac;
    assign frac_off    = state_q.dsm_off;
    assign pwr_down    = state_q.pd;
    assign loop_rst    = state_q.lrst;
    assign pll_enabled = ~state_q.pd;
    assign rd_data     = state_q.rd;
endmodule

// File: rtl/pll_ctrl_regs_chk.sv
module pll_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [3:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic [31:0] rd_data,
    input logic [11:0] fb_div,
    input logic [5:0]  ref_div,
    input logic [2:0]  out_div_a,
    input logic [2:0]  out_div_b,
    input logic [23:0] frac_val,
    input logic        frac_off,
    input logic        pwr_down,
    input logic        loop_rst
);
    logic [53:0] fields;
    assign fields = {fb_div, ref_div, out_div_a, out_div_b, frac_val,
                     frac_off, pwr_down, loop_rst};

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fields));

    p_zero_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[3:2] == 2'd0 && req_wdata[27:16] == 12'd0)
        |=> $stable(fb_div));

    p_frac_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[3:2] == 2'd2)
        |=> frac_val == $past(req_wdata[23:0]));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rd_data));

    p_rd_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[3:2] != 2'd2)
        |=> rd_data[31:16] == 16'd0);

    p_frac_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[3:2] == 2'd2)
        |=> rd_data[30:24] == 7'd0);
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_data   (rd_data),
    .fb_div    (fb_div),
    .ref_div   (ref_div),
    .out_div_a (out_div_a),
    .out_div_b (out_div_b),
    .frac_val  (frac_val),
    .frac_off  (frac_off),
    .pwr_down  (pwr_down),
    .loop_rst  (loop_rst)
);

// File: tb/tb_pll_ctrl_regs.sv
module tb_pll_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        lock_in = 1'b0;
    logic [31:0] rd_data;
    logic [11:0] fb_div;
    logic [5:0]  ref_div;
    logic [2:0]  out_div_a, out_div_b;
    logic [23:0] frac_val;
    logic        frac_off, pwr_down, loop_rst, pll_enabled;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pll_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .lock_in(lock_in), .fb_div(fb_div), .ref_div(ref_div),
        .out_div_a(out_div_a), .out_div_b(out_div_b), .frac_val(frac_val),
        .frac_off(frac_off), .pwr_down(pwr_down), .loop_rst(loop_rst),
        .pll_enabled(pll_enabled)
    );

    // behavioural model: one 16-bit image per masked word, plus fraction and read data
    logic [15:0] m_img [4];
    logic [23:0] m_frac;
    logic [31:0] m_rd;
    logic [15:0] keep [4];
    initial begin
        keep[0] = 16'h0FFF; keep[1] = 16'h773F; keep[2] = 16'h0000; keep[3] = 16'h0029;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_img[0] = 16'd50; m_img[1] = 16'h1101; m_img[2] = 16'h0; m_img[3] = 16'h0008;
            m_frac = '0; m_rd = '0;
        end else if (req_valid) begin
            int w;
            w = int'(req_addr[3:2]);
            if (req_write) begin
                if (w == 2) m_frac = req_wdata[23:0];
                else begin
                    for (int k = 0; k < 16; k++)
                        if (req_wdata[16+k]) m_img[w][k] = req_wdata[k];
                    m_img[w] = m_img[w] & keep[w];
                end
            end else begin
                if (w == 2) m_rd = {lock_in, 7'd0, m_frac};
                else m_rd = {16'd0, m_img[w]};
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R3, R4, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(fb_div == m_img[0][11:0], "R3 fb model", 32'(fb_div), 32'(m_img[0][11:0]));
            check({out_div_b, out_div_a, ref_div} == {m_img[1][14:12], m_img[1][10:8], m_img[1][5:0]},
                  "R3 div model", {20'd0, out_div_b, out_div_a, ref_div},
                  {20'd0, m_img[1][14:12], m_img[1][10:8], m_img[1][5:0]});
            check(frac_val == m_frac, "R5 frac model", 32'(frac_val), 32'(m_frac));
            check({loop_rst, frac_off, pwr_down, pll_enabled} ==
                  {m_img[3][5], m_img[3][3], m_img[3][0], ~m_img[3][0]}, "R4 ctl model",
                  {28'd0, loop_rst, frac_off, pwr_down, pll_enabled},
                  {28'd0, m_img[3][5], m_img[3][3], m_img[3][0], ~m_img[3][0]});
            check(rd_data == m_rd, "R8 rd model", rd_data, m_rd);
        end
    end

    task automatic op(input bit v, input bit wr, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = v; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({fb_div, ref_div, out_div_a, out_div_b} == {12'd50, 6'd1, 3'd1, 3'd1}, "R1 dividers",
              {8'd0, fb_div, ref_div, out_div_a, out_div_b}, {8'd0, 12'd50, 6'd1, 3'd1, 3'd1});
        check({frac_val, frac_off, pwr_down, loop_rst, pll_enabled} == {24'd0, 4'b1001}, "R1 control",
              {4'd0, frac_val, frac_off, pwr_down, loop_rst, pll_enabled}, {4'd0, 24'd0, 4'b1001});
        check(rd_data == 32'd0, "R1 rd_data", rd_data, 32'd0);

        op(1, 1, 4'h0, 32'hFFFF_0123);
        check(fb_div == 12'h123, "R3 full mask fb", 32'(fb_div), 32'h123);
        op(1, 1, 4'h0, 32'h000F_0FFF);
        check(fb_div == 12'h12F, "R2 partial mask", 32'(fb_div), 32'h12F);
        op(1, 1, 4'h0, 32'h0000_0FFF);
        check(fb_div == 12'h12F, "R2 zero mask", 32'(fb_div), 32'h12F);
        op(1, 1, 4'h4, 32'h7FFF_4205);
        check({out_div_b, out_div_a, ref_div} == {3'd4, 3'd2, 6'd5}, "R3 div fields",
              {20'd0, out_div_b, out_div_a, ref_div}, {20'd0, 3'd4, 3'd2, 6'd5});
        op(1, 1, 4'h8, 32'hFFAB_CDEF);
        check(frac_val == 24'hABCDEF, "R5 frac write", 32'(frac_val), 32'hABCDEF);

        lock_in = 1'b1;
        op(1, 0, 4'h8, 32'h0);
        check(rd_data == 32'h80AB_CDEF, "R6 read locked", rd_data, 32'h80AB_CDEF);
        lock_in = 1'b0;
        op(1, 0, 4'h8, 32'h0);
        check(rd_data == 32'h00AB_CDEF, "R6 read unlocked", rd_data, 32'h00AB_CDEF);

        op(1, 1, 4'hC, 32'h0001_0001);
        check(pwr_down && !pll_enabled, "R4 powerdown", {30'd0, pwr_down, pll_enabled}, 32'd2);
        op(1, 1, 4'hC, 32'h0008_0000);
        check(!frac_off && pwr_down, "R4 frac mode on", {30'd0, frac_off, pwr_down}, 32'd1);
        op(1, 1, 4'hC, 32'h0020_0020);
        check(loop_rst, "R4 loop reset", 32'(loop_rst), 32'd1);

        op(1, 0, 4'h1, 32'h0);
        check(rd_data == 32'h0000_012F, "R9 low addr bits", rd_data, 32'h0000_012F);
        op(1, 1, 4'h7, 32'h0001_0000);
        check(ref_div == 6'd4, "R9 addr 0x7 is div word", 32'(ref_div), 32'd4);

        op(0, 1, 4'h0, 32'hFFFF_0000);
        check(fb_div == 12'h12F, "R10 idle write", 32'(fb_div), 32'h12F);
        op(0, 1, 4'h8, 32'h0000_0000);
        check(frac_val == 24'hABCDEF, "R10 idle frac", 32'(frac_val), 32'hABCDEF);

        op(1, 1, 4'h0, 32'hF000_F000);
        op(1, 0, 4'h0, 32'h0);
        check(rd_data == 32'h0000_012F, "R7 unused bits", rd_data, 32'h0000_012F);
        op(1, 0, 4'hC, 32'h0);
        check(rd_data == 32'h0000_0021, "R7 ctl word", rd_data, 32'h0000_0021);
        held = rd_data;
        op(1, 1, 4'h4, 32'hFFFF_FFFF);
        @(negedge clk);
        check(rd_data == held, "R8 hold after write", rd_data, held);
        op(1, 0, 4'h4, 32'h0);
        check(rd_data == 32'h0000_773F, "R7 div word", rd_data, 32'h0000_773F);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule